// File: doc/BRIEF.md
# Lock-Aware Bus Arbiter

This block decides which of several initiators may drive a shared parallel bus, and it also keeps track of which initiator holds exclusive access. Request lines come in and one-hot grant lines go out. The arbiter also watches the bus transaction strobe, the exclusive-access strobe and the address. Holding a grant is not the same as holding the lock. An initiator becomes lock owner only through a separate two-step handshake on the exclusive-access strobe. The lock covers an aligned 16-byte block of the address space.

A mode input selects one of two lock policies:

- **Whole-bus mode.** While a lock is held, only the owner and one designated cache-writeback requester can be granted. The writeback requester must stay able to flush a modified line after a snoop hit.
- **Region mode.** Every initiator stays eligible. A registered flag reports whether the address of a non-owner transaction falls inside the locked block.

While a lock is held, the block raises a write-posting-disable output.

Top module: `lock_arbiter`

## Requirements
- R1: After reset all grant lines, the lock-held flag, the owner index, the write-posting-disable output and the region flag are all zero.
- R2: At most one grant line is high at any time. A grant only ever changes by passing through a cycle with no grant. A new grant is issued only at a clock edge where `bus_frame` is sampled low.
- R3: Grants rotate round-robin. The arbiter picks the first eligible requester at the index after the last granted one, wrapping around. After reset the last granted index counts as N-1, so initiator 0 ranks first. A grant stays while its request stays high and eligible. It is removed at the first edge where that no longer holds, and a new grant can follow one edge later.
- R4: An initiator takes the lock when two edges occur in a row. First, an address-phase edge where `bus_frame` is sampled high after being low in the previous cycle, while that initiator is granted and `bus_lock` is low. Second, the very next edge, where `bus_lock` is high. The lock owner index and the lock-held flag show after that second edge. A grant followed by a transaction that already has `bus_lock` high at its address phase gives no lock.
- R5: The lock is released at an edge where both `bus_frame` and `bus_lock` are low and the last transaction was started by the owner. A lock that is still held at the end of a non-owner transaction is kept.
- R6: In whole-bus mode (`full_lock`=1), while a lock is held, only the owner and the writeback requester (index WB_IDX, default 3) can be granted. Any other request is held off.
- R7: In region mode (`full_lock`=0), and in either mode when no lock is held, every requesting initiator is eligible.
- R8: At each address-phase edge, `region_hit` is loaded with 1 if all three of these hold: a lock is held, the granted initiator is not the owner, and the address matches the captured lock address in every bit above bit 3. Otherwise it is loaded with 0. It is cleared when the lock is released.
- R9: `post_dis` is high exactly while a lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Request line per initiator |
| bus_frame | input | 1 | Transaction in progress (active high) |
| bus_lock | input | 1 | Exclusive-access strobe (active high) |
| bus_addr | input | AW | Bus address, valid at address phase |
| full_lock | input | 1 | 1 = whole-bus locking, 0 = region locking |
| gnt | output | N | One-hot grant lines |
| lock_held | output | 1 | A lock owner exists |
| lock_owner | output | IW | Index of the lock owner (0 when no lock is held) |
| post_dis | output | 1 | Write-posting disable |
| region_hit | output | 1 | Last address phase of a non-owner hit the locked block |

## Verification
Every output is a register, so each result is due one edge after the input that causes it. The bench drives inputs just after a rising edge and reads outputs just after the next one.

Some results take two edges:

- **Lock ownership** needs the address-phase edge and then the strobe edge. The bench checks `lock_held` only after the second edge.
- **A grant after a drop** needs the edge that removes the old grant and then the edge that issues the new one. The bench checks that the grant lines are zero between those two edges.

The round-robin sweep walks every nonzero request pattern twice. A bench model keeps its own rotation point to predict each grant.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;

  // Round-robin search: first set bit of elig after index last, wrapping at n.
  // Returns n when nothing is eligible.
  function automatic int unsigned rr_next(input logic [31:0] elig,
                                          input int unsigned last,
                                          input int unsigned n);
    int unsigned idx;
    for (int unsigned k = 1; k <= 32; k++) begin
      if (k <= n) begin
        idx = (last + k) % n;
        if (elig[idx]) return idx;
      end
    end
    return n;
  endfunction

  // Two addresses fall in the same aligned 16-byte block.
  function automatic logic same_block(input logic [63:0] a, input logic [63:0] b);
    return a[63:4] == b[63:4];
  endfunction

endpackage

// File: rtl/lockarb_grant.sv
module lockarb_grant #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  input  logic          bus_frame,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  import lockarb_pkg::*;

  logic [IW-1:0] last_q;
  logic [31:0]   elig_ext;
  int unsigned   pick;
  logic          grant_issue;
  logic          grant_drop;

  always_comb begin
    elig_ext = '0;
    elig_ext[N-1:0] = elig;
    pick = rr_next(elig_ext, 32'(last_q), N);
  end

  assign gnt_any     = |gnt;
  assign grant_drop  = gnt_any && !elig[gnt_idx];
  assign grant_issue = !gnt_any && !bus_frame && (pick < N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt     <= '0;
      gnt_idx <= '0;
      last_q  <= IW'(N - 1);
    end else if (grant_drop) begin
      gnt <= '0;
    end else if (grant_issue) begin
      gnt     <= N'(1) << pick;
      gnt_idx <= IW'(pick);
      last_q  <= IW'(pick);
    end
  end

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_change_via_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |=> (gnt == '0 || $stable(gnt)));
  assert_issue_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && $past(gnt) == '0) |-> !$past(bus_frame));
  assert_grant_was_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && $past(gnt) == '0) |-> (($past(elig) & gnt) != '0));

endmodule

// File: rtl/lockarb_lock.sv
module lockarb_lock #(
  parameter int N  = 4,
  parameter int IW = $clog2(N),
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_frame,
  input  logic          bus_lock,
  input  logic [AW-1:0] bus_addr,
  input  logic          gnt_any,
  input  logic [IW-1:0] gnt_idx,
  output logic          lock_held,
  output logic [IW-1:0] lock_owner,
  output logic          region_hit
);
  import lockarb_pkg::*;

  logic          frame_q;
  logic          armed;
  logic [IW-1:0] cand;
  logic [AW-1:0] cap_addr;
  logic [AW-1:0] lock_addr;
  logic [IW-1:0] cur_master;
  logic [63:0]   addr_ext, lock_ext;

  logic addr_phase, lock_take, lock_release, blk_match;

  always_comb begin
    addr_ext = '0;
    lock_ext = '0;
    addr_ext[AW-1:0] = bus_addr;
    lock_ext[AW-1:0] = lock_addr;
  end

  assign addr_phase   = bus_frame && !frame_q;
  assign blk_match    = same_block(addr_ext, lock_ext);
  assign lock_take    = armed && bus_lock;
  assign lock_release = lock_held && (cur_master == lock_owner) && !bus_frame && !bus_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q    <= 1'b0;
      armed      <= 1'b0;
      cand       <= '0;
      cap_addr   <= '0;
      lock_addr  <= '0;
      cur_master <= '0;
      lock_held  <= 1'b0;
      lock_owner <= '0;
      region_hit <= 1'b0;
    end else begin
      frame_q <= bus_frame;
      armed   <= addr_phase && gnt_any && !bus_lock && !lock_held;
      if (addr_phase) begin
        cand       <= gnt_idx;
        cap_addr   <= bus_addr;
        if (gnt_any) cur_master <= gnt_idx;
        region_hit <= lock_held && gnt_any && (gnt_idx != lock_owner) && blk_match;
      end
      if (lock_take) begin
        lock_held  <= 1'b1;
        lock_owner <= cand;
        lock_addr  <= cap_addr;
      end else if (lock_release) begin
        lock_held  <= 1'b0;
        lock_owner <= '0;
        region_hit <= 1'b0;
      end
    end
  end

  assert_take_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_held) |-> $past(bus_lock));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_release |=> !lock_held);
  assert_owner_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_held && $past(lock_held)) |-> $stable(lock_owner));
  assert_hit_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    region_hit |-> lock_held);

endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter #(
  parameter int N      = 4,
  parameter int AW     = 32,
  parameter int WB_IDX = 3,
  parameter int IW     = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          bus_frame,
  input  logic          bus_lock,
  input  logic [AW-1:0] bus_addr,
  input  logic          full_lock,
  output logic [N-1:0]  gnt,
  output logic          lock_held,
  output logic [IW-1:0] lock_owner,
  output logic          post_dis,
  output logic          region_hit
);
  localparam logic [N-1:0] WB_MASK = N'(1) << WB_IDX;

  logic [N-1:0]  elig;
  logic [N-1:0]  allowed;
  logic [IW-1:0] gnt_idx;
  logic          gnt_any;

  assign allowed = (full_lock && lock_held) ? ((N'(1) << lock_owner) | WB_MASK) : '1;
  assign elig    = req & allowed;
  assign post_dis = lock_held;

  lockarb_grant #(.N(N), .IW(IW)) u_grant (
    .clk(clk), .rst_n(rst_n), .elig(elig), .bus_frame(bus_frame),
    .gnt(gnt), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  lockarb_lock #(.N(N), .IW(IW), .AW(AW)) u_lock (
    .clk(clk), .rst_n(rst_n), .bus_frame(bus_frame), .bus_lock(bus_lock),
    .bus_addr(bus_addr), .gnt_any(gnt_any), .gnt_idx(gnt_idx),
    .lock_held(lock_held), .lock_owner(lock_owner), .region_hit(region_hit)
  );

  assert_full_lock_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_lock && lock_held && $past(lock_held) && $past(full_lock) && gnt != '0)
      |-> ((gnt & ~((N'(1) << lock_owner) | WB_MASK)) == '0));

endmodule

// File: tb/lock_arbiter_bench.sv
`timescale 1ns/1ps
module lock_arbiter_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic        bus_frame = 1'b0, bus_lock = 1'b0, full_lock = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [3:0]  gnt;
  logic        lock_held, post_dis, region_hit;
  logic [1:0]  lock_owner;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lock_arbiter u_lock_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_frame(bus_frame), .bus_lock(bus_lock),
    .bus_addr(bus_addr), .full_lock(full_lock), .gnt(gnt), .lock_held(lock_held),
    .lock_owner(lock_owner), .post_dis(post_dis), .region_hit(region_hit)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int model_pick(input int p, input int last);
    for (int k = 1; k <= 4; k++) begin
      if (p[(last + k) % 4]) return (last + k) % 4;
    end
    return -1;
  endfunction

  int last;

  initial begin
    repeat (3) tick();
    // R1 reset state
    check("R1 gnt", gnt, 0);
    check("R1 lock_held", lock_held, 0);
    check("R1 owner", lock_owner, 0);
    check("R1 post_dis", post_dis, 0);
    check("R1 region_hit", region_hit, 0);
    rst_n = 1'b1;
    tick();
    last = 3;

    // R3 sweep: every nonzero request pattern, twice
    for (int rep = 0; rep < 2; rep++) begin
      for (int p = 1; p < 16; p++) begin
        int e;
        req = 4'(p);
        tick();
        e = model_pick(p, last);
        check("R3 pick", gnt, 32'(1) << e);
        last = e;
        tick();
        check("R3 hold", gnt, 32'(1) << e);
        req = '0;
        tick();
        check("R2 drop to zero", gnt, 0);
      end
    end

    // R2: no new grant while frame is sampled high
    bus_frame = 1'b1; req = 4'b0001;
    tick();
    check("R2 busy no grant", gnt, 0);
    bus_frame = 1'b0;
    tick();
    check("R2 idle grant", gnt, 4'b0001);
    req = '0; tick();

    // R4: grant plus a transaction whose lock is high at address phase gives no lock
    req = 4'b0010; tick();
    check("R7 grant 1", gnt, 4'b0010);
    bus_frame = 1'b1; bus_lock = 1'b1; bus_addr = 32'h100; tick();
    tick();
    check("R4 no lock without handshake", lock_held, 0);
    bus_frame = 1'b0; bus_lock = 1'b0; tick();

    // R4: proper handshake by initiator 1
    bus_frame = 1'b1; bus_lock = 1'b0; bus_addr = 32'h1230; tick();
    check("R4 not yet held", lock_held, 0);
    bus_lock = 1'b1; tick();
    check("R4 held", lock_held, 1);
    check("R4 owner", lock_owner, 1);
    check("R9 post_dis on", post_dis, 1);
    bus_frame = 1'b0; tick();
    req = '0; tick();
    check("R5 kept across owner idle", lock_held, 1);

    // R7/R8: region mode, initiator 0 inside and outside the locked block
    req = 4'b0001; tick();
    check("R7 region mode grant", gnt, 4'b0001);
    bus_frame = 1'b1; bus_addr = 32'h1238; tick();
    check("R8 hit same block", region_hit, 1);
    bus_frame = 1'b0; tick();
    check("R5 kept after non-owner end", lock_held, 1);
    bus_frame = 1'b1; bus_addr = 32'h1240; tick();
    check("R8 miss next block", region_hit, 0);
    bus_frame = 1'b0; req = '0; tick(); tick();

    // R6: whole-bus mode holds off non-owners except the writeback requester
    full_lock = 1'b1; req = 4'b0101; tick(); tick();
    check("R6 others held off", gnt, 0);
    req = 4'b1101; tick();
    check("R6 writeback granted", gnt, 4'b1000);
    req = 4'b0101; tick();
    check("R6 writeback dropped", gnt, 0);
    tick();
    check("R6 still held off", gnt, 0);
    req = 4'b0111; tick();
    check("R6 owner granted", gnt, 4'b0010);

    // R5: owner transaction ends with both strobes low
    bus_frame = 1'b1; bus_lock = 1'b1; bus_addr = 32'h1230; tick();
    check("R8 owner no hit", region_hit, 0);
    tick();
    bus_frame = 1'b0; bus_lock = 1'b0; tick();
    check("R5 released", lock_held, 0);
    check("R9 post_dis off", post_dis, 0);
    check("R5 owner cleared", lock_owner, 0);

    // R7: after release everyone is eligible again, rotation continues after 1
    req = 4'b0101; tick();
    check("R3 drop on release of req", gnt, 0);
    tick();
    check("R7 rotation after release", gnt, 4'b0100);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule